// File: doc/BRIEF.md
# Inter-Port Semaphore Flag Unit

This block keeps a small set of hardware semaphore flags that two independent ports share. Software on either side uses the flags to claim and hand back regions of a memory that both ports can reach. A port claims a flag by writing 0 to it and hands it back by writing 1. A claim that meets a flag held by the other port stays pending. The flag passes to that pending claimant as soon as the owner releases it. Reading a flag tells the reading port whether it holds that flag, and the answer is copied onto every bit of the data bus.

Each port has an active-low semaphore select, an active-low chip enable, a read/write line, an active-low output enable, two byte-lane selects, an address and a data bus. A port reaches a semaphore only while its chip enable is inactive. Driving both selects low at once is an illegal combination. The block discards such a cycle and flags an error for it. All state changes on the rising clock edge. Read data and the error indication are combinational from the current inputs and the stored flags.

Top module: `dpSemaphore`

## Requirements
- R1: After reset all eight flags are free, so either port reads 16'hFFFF from every flag.
- R2: The flag is picked by address bits 2:0. Address bits above bit 2 have no effect on which flag is read or written.
- R3: A write takes its value from data bit 0 alone. A 0 is a request and a 1 is a release. Data bits 15:1 have no effect.
- R4: During a read cycle the read-valid output is 1. The data is 16'h0000 when the reading port owns the flag and 16'hFFFF otherwise, whatever the byte-lane selects are. Outside a read cycle the read-valid output is 0 and the data is 16'h0000.
- R5: A port takes part in a semaphore access only when its semaphore select is 0 and its chip enable is 1. With the semaphore select at 1 the port causes no flag change and no read.
- R6: Semaphore select 0 together with chip enable 0 drives that port's error output to 1 in that cycle. The cycle changes no flag and produces no read data.
- R7: A read needs read/write at 1 and output enable at 0. A write needs read/write at 0, whatever the output enable is. With read/write at 1 and output enable at 1 nothing happens.
- R8: A request for a flag that the other port owns is not granted. The other port stays owner and the request is held pending.
- R9: A release takes effect only when the writing port owns the flag. A release from a non-owner leaves the owner in place and withdraws the non-owner's pending request.
- R10: When both ports request the same free flag in the same cycle, port A is granted it.
- R11: When the owner releases a flag on which the other port has a pending request, that other port owns the flag from the next cycle.
- R12: A write's effect is visible to reads from the cycle after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aSemN | input | 1 | Port A semaphore select, active low |
| aCeN | input | 1 | Port A chip enable, active low (must be 1 for semaphore access) |
| aWrN | input | 1 | Port A read/write: 0 write, 1 read |
| aOeN | input | 1 | Port A output enable, active low |
| aUbN | input | 1 | Port A upper byte select, active low |
| aLbN | input | 1 | Port A lower byte select, active low |
| aAddr | input | ADDR_W | Port A address; bits 2:0 pick the flag |
| aWdata | input | DATA_W | Port A write data; bit 0 is used |
| aRdata | output | DATA_W | Port A flag read data |
| aRdValid | output | 1 | Port A read cycle in progress |
| aErr | output | 1 | Port A illegal select combination |
| bSemN | input | 1 | Port B semaphore select, active low |
| bCeN | input | 1 | Port B chip enable, active low |
| bWrN | input | 1 | Port B read/write: 0 write, 1 read |
| bOeN | input | 1 | Port B output enable, active low |
| bUbN | input | 1 | Port B upper byte select, active low |
| bLbN | input | 1 | Port B lower byte select, active low |
| bAddr | input | ADDR_W | Port B address; bits 2:0 pick the flag |
| bWdata | input | DATA_W | Port B write data; bit 0 is used |
| bRdata | output | DATA_W | Port B flag read data |
| bRdValid | output | 1 | Port B read cycle in progress |
| bErr | output | 1 | Port B illegal select combination |

## Verification
Any wrong owner or pending bit shows on the very next read of that flag. The read returns the wrong one of 16'h0000 and 16'hFFFF, one cycle after the write that caused the fault. A lost pending request stays hidden until the owner releases the flag. At that release the waiting port reads all ones instead of all zeros, so the bench releases flags on purpose after building up contention. Cross-talk between flags or a wrongly decoded address shows as a change on a neighbouring flag. The bench therefore reads untouched flags and varies the upper address and data bits.

// File: rtl/semPkg.sv
package semPkg;
  parameter int SEM_FLAGS = 8;
  localparam int SEM_IDX_W = $clog2(SEM_FLAGS);

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_t;

  // Strobes from a port decoder to the flag bank and read path
  typedef struct packed {
    logic [SEM_FLAGS-1:0] req;
    logic [SEM_FLAGS-1:0] rel;
    logic                 rd;
    logic [SEM_IDX_W-1:0] idx;
    logic                 err;
  } semStrobe_t;
endpackage

// File: rtl/semPortDecode.sv
module semPortDecode
  import semPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              semN,
  input  logic              ceN,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              ubN,
  input  logic              lbN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output semStrobe_t        stb
);
  logic                 access;
  logic                 wrCyc;
  logic [SEM_FLAGS-1:0] flagSel;
  logic                 unusedBits;

  // Byte lanes, upper address bits and upper data bits play no part
  assign unusedBits = ^{ubN, lbN, addr[ADDR_W-1:SEM_IDX_W], wdata[DATA_W-1:1]};

  assign access  = ~semN & ceN;
  assign wrCyc   = access & ~wrN;
  assign flagSel = SEM_FLAGS'(1) << addr[SEM_IDX_W-1:0];

  always_comb begin
    stb.idx = addr[SEM_IDX_W-1:0];
    stb.err = ~semN & ~ceN;
    stb.rd  = access & wrN & ~oeN;
    stb.req = (wrCyc && !wdata[0]) ? flagSel : '0;
    stb.rel = (wrCyc &&  wdata[0]) ? flagSel : '0;
  end
endmodule

// File: rtl/semFlagBank.sv
module semFlagBank
  import semPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  semStrobe_t                stbA,
  input  semStrobe_t                stbB,
  output logic [SEM_FLAGS-1:0][1:0] flagOwner
);
  for (genvar i = 0; i < SEM_FLAGS; i++) begin : g_flag
    owner_t ownQ, ownNext;
    logic   wantAQ, wantBQ;
    logic   wantANext, wantBNext;

    always_comb begin
      wantANext = (wantAQ | stbA.req[i]) & ~stbA.rel[i];
      wantBNext = (wantBQ | stbB.req[i]) & ~stbB.rel[i];
      ownNext   = ownQ;
      unique case (ownQ)
        OWN_A: if (stbA.rel[i]) ownNext = wantBNext ? OWN_B : OWN_NONE;
        OWN_B: if (stbB.rel[i]) ownNext = wantANext ? OWN_A : OWN_NONE;
        default: begin
          if (wantANext)      ownNext = OWN_A;
          else if (wantBNext) ownNext = OWN_B;
          else                ownNext = OWN_NONE;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ownQ   <= OWN_NONE;
        wantAQ <= 1'b0;
        wantBQ <= 1'b0;
      end else begin
        ownQ   <= ownNext;
        wantAQ <= wantANext;
        wantBQ <= wantBNext;
      end
    end

    assign flagOwner[i] = ownQ;
  end
endmodule

// File: rtl/dpSemaphore.sv
module dpSemaphore
  import semPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aSemN,
  input  logic              aCeN,
  input  logic              aWrN,
  input  logic              aOeN,
  input  logic              aUbN,
  input  logic              aLbN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aRdValid,
  output logic              aErr,
  input  logic              bSemN,
  input  logic              bCeN,
  input  logic              bWrN,
  input  logic              bOeN,
  input  logic              bUbN,
  input  logic              bLbN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bRdValid,
  output logic              bErr
);
  localparam int PORTS = 2;

  logic [PORTS-1:0]             semNv, ceNv, wrNv, oeNv, ubNv, lbNv;
  logic [PORTS-1:0][ADDR_W-1:0] addrV;
  logic [PORTS-1:0][DATA_W-1:0] wdataV, rdataV;
  semStrobe_t                   portStb [PORTS];
  logic [SEM_FLAGS-1:0][1:0]    flagOwner;

  assign semNv  = {bSemN, aSemN};
  assign ceNv   = {bCeN, aCeN};
  assign wrNv   = {bWrN, aWrN};
  assign oeNv   = {bOeN, aOeN};
  assign ubNv   = {bUbN, aUbN};
  assign lbNv   = {bLbN, aLbN};
  assign addrV  = {bAddr, aAddr};
  assign wdataV = {bWdata, aWdata};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam owner_t MINE = (p == 0) ? OWN_A : OWN_B;

    semPortDecode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .semN (semNv[p]),
      .ceN  (ceNv[p]),
      .wrN  (wrNv[p]),
      .oeN  (oeNv[p]),
      .ubN  (ubNv[p]),
      .lbN  (lbNv[p]),
      .addr (addrV[p]),
      .wdata(wdataV[p]),
      .stb  (portStb[p])
    );

    // Status replicated across the whole bus: 0 means this port holds the flag
    assign rdataV[p] = portStb[p].rd ?
                       {DATA_W{flagOwner[portStb[p].idx] != MINE}} : '0;
  end

  semFlagBank u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .stbA     (portStb[0]),
    .stbB     (portStb[1]),
    .flagOwner(flagOwner)
  );

  assign aRdata   = rdataV[0];
  assign bRdata   = rdataV[1];
  assign aRdValid = portStb[0].rd;
  assign bRdValid = portStb[1].rd;
  assign aErr     = portStb[0].err;
  assign bErr     = portStb[1].err;
endmodule

// File: rtl/semChk.sv
module semChk
  import semPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input semStrobe_t                stbA,
  input semStrobe_t                stbB,
  input logic [SEM_FLAGS-1:0][1:0] flagOwner,
  input logic [DATA_W-1:0]         aRdata,
  input logic                      aRdValid,
  input logic                      aErr,
  input logic [DATA_W-1:0]         bRdata,
  input logic                      bRdValid,
  input logic                      bErr
);
  // R4
  a_replicated_chk: assert property (@(posedge clk) disable iff (!rstN)
    aRdValid |-> (aRdata == '0 || aRdata == '1));
  // R4
  b_replicated_chk: assert property (@(posedge clk) disable iff (!rstN)
    bRdValid |-> (bRdata == '0 || bRdata == '1));
  // R4
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aRdValid |-> aRdata == '0) and (!bRdValid |-> bRdata == '0));
  // R6
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aErr |-> !aRdValid) and (bErr |-> !bRdValid));
  // R6
  err_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aErr && bErr) |=> $stable(flagOwner));

  for (genvar i = 0; i < SEM_FLAGS; i++) begin : g_flagChk
    // R10
    tie_a_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stbA.req[i] && stbB.req[i] && flagOwner[i] == OWN_NONE)
        |=> flagOwner[i] == OWN_A);
    // R8
    a_held_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagOwner[i] == OWN_A && !stbA.rel[i]) |=> flagOwner[i] == OWN_A);
    // R9
    b_held_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagOwner[i] == OWN_B && !stbB.rel[i]) |=> flagOwner[i] == OWN_B);
  end
endmodule

bind dpSemaphore semChk #(.DATA_W(DATA_W)) u_semChk (
  .clk      (clk),
  .rstN     (rstN),
  .stbA     (portStb[0]),
  .stbB     (portStb[1]),
  .flagOwner(flagOwner),
  .aRdata   (aRdata),
  .aRdValid (aRdValid),
  .aErr     (aErr),
  .bRdata   (bRdata),
  .bRdValid (bRdValid),
  .bErr     (bErr)
);

// File: tb/dpSemaphore_bench.sv
module dpSemaphore_bench;
  localparam int CLK_P = 10;
  localparam int NF    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aSemN, aCeN, aWrN, aOeN, aUbN, aLbN;
  logic bSemN, bCeN, bWrN, bOeN, bUbN, bLbN;
  logic [11:0] aAddr, bAddr;
  logic [15:0] aWdata, bWdata, aRdata, bRdata;
  logic aRdValid, bRdValid, aErr, bErr;

  int checks = 0;
  int errCnt = 0;
  bit done = 1'b0;

  // bench model: own 0 free, 1 port A, 2 port B
  int own [NF];
  bit wantA [NF];
  bit wantB [NF];

  always #(CLK_P/2) clk = ~clk;

  dpSemaphore u_dpSemaphore (
    .clk(clk), .rstN(rstN),
    .aSemN(aSemN), .aCeN(aCeN), .aWrN(aWrN), .aOeN(aOeN), .aUbN(aUbN), .aLbN(aLbN),
    .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata), .aRdValid(aRdValid), .aErr(aErr),
    .bSemN(bSemN), .bCeN(bCeN), .bWrN(bWrN), .bOeN(bOeN), .bUbN(bUbN), .bLbN(bLbN),
    .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata), .bRdValid(bRdValid), .bErr(bErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setPort(input int p, input logic sem, input logic ce, input logic wr,
                         input logic oe, input logic ub, input logic lb,
                         input logic [11:0] ad, input logic [15:0] wd);
    if (p == 0) begin
      aSemN = sem; aCeN = ce; aWrN = wr; aOeN = oe; aUbN = ub; aLbN = lb;
      aAddr = ad; aWdata = wd;
    end else begin
      bSemN = sem; bCeN = ce; bWrN = wr; bOeN = oe; bUbN = ub; bLbN = lb;
      bAddr = ad; bWdata = wd;
    end
  endtask

  task automatic idleAll();
    setPort(0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h0, 16'h0);
    setPort(1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h0, 16'h0);
  endtask

  task automatic modelStep(input bit [NF-1:0] qa, input bit [NF-1:0] la,
                           input bit [NF-1:0] qb, input bit [NF-1:0] lb);
    for (int i = 0; i < NF; i++) begin
      bit wa, wb;
      wa = (wantA[i] | qa[i]) & ~la[i];
      wb = (wantB[i] | qb[i]) & ~lb[i];
      if (own[i] == 1) begin
        if (la[i]) own[i] = wb ? 2 : 0;
      end else if (own[i] == 2) begin
        if (lb[i]) own[i] = wa ? 1 : 0;
      end else begin
        own[i] = wa ? 1 : (wb ? 2 : 0);
      end
      wantA[i] = wa;
      wantB[i] = wb;
    end
  endtask

  // One cycle of legal writes on either or both ports, with junk in unused bits
  task automatic writeCycle(input bit enA, input int ia, input bit va,
                            input bit enB, input int ib, input bit vb,
                            input logic [15:0] junk);
    bit [NF-1:0] qa, la, qb, lb;
    qa = '0; la = '0; qb = '0; lb = '0;
    if (enA) begin
      setPort(0, 1'b0, 1'b1, 1'b0, junk[0], junk[1], junk[2],
              {junk[11:3], 3'(ia)}, {junk[15:1], va});
      if (va) la[ia] = 1'b1; else qa[ia] = 1'b1;
    end
    if (enB) begin
      setPort(1, 1'b0, 1'b1, 1'b0, ~junk[0], junk[2], junk[1],
              {~junk[11:3], 3'(ib)}, {~junk[15:1], vb});
      if (vb) lb[ib] = 1'b1; else qb[ib] = 1'b1;
    end
    @(negedge clk);
    modelStep(qa, la, qb, lb);
    idleAll();
  endtask

  task automatic checkRead(input int p, input int idx, input logic ub, input logic lb,
                           input string tag);
    logic [15:0] exp, act;
    logic v;
    setPort(p, 1'b0, 1'b1, 1'b1, 1'b0, ub, lb, {9'h1A5, 3'(idx)}, 16'h0);
    #1;
    exp = (own[idx] == p + 1) ? 16'h0000 : 16'hFFFF;
    act = (p == 0) ? aRdata : bRdata;
    v   = (p == 0) ? aRdValid : bRdValid;
    check(act == exp && v, tag, int'({v, act}), int'({1'b1, exp}));
    @(negedge clk);
    idleAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog R12 act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < NF; i++) begin own[i] = 0; wantA[i] = 0; wantB[i] = 0; end
    idleAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, byte lanes varied for R4
    for (int i = 0; i < NF; i++)
      for (int p = 0; p < 2; p++)
        checkRead(p, i, 1'(i), 1'(i >> 1), "R1 reset flag free");
    check(!aErr && !bErr, "R1 no error idle", int'({aErr, bErr}), 0);

    // Request / pending / pass-on sweep over every flag
    for (int i = 0; i < NF; i++) begin
      writeCycle(1, i, 0, 0, 0, 0, 16'h1357 * 16'(i + 1));
      checkRead(0, i, 0, 1, "R12 A owns after request");
      checkRead(1, i, 1, 0, "R8 B sees flag held");
      checkRead(0, (i + 1) % NF, 0, 0, "R2 neighbour untouched");
      writeCycle(0, 0, 0, 1, i, 0, 16'hFFFE);
      checkRead(1, i, 0, 0, "R8 B request not granted");
      checkRead(0, i, 1, 1, "R8 A keeps flag");
      writeCycle(1, i, 1, 0, 0, 0, 16'h0000);
      checkRead(1, i, 0, 0, "R11 passed to waiting B");
      checkRead(0, i, 0, 0, "R11 A lost flag");
      writeCycle(0, 0, 0, 1, i, 1, 16'hAAAA);
      checkRead(1, i, 0, 0, "R3 B release via bit0");
      checkRead(0, i, 0, 0, "R3 free after release");
    end

    // R10 tie-break, R9 foreign release withdraws pending request
    for (int i = 0; i < NF; i++) begin
      writeCycle(1, i, 0, 1, i, 0, 16'h5A5A);
      checkRead(0, i, 0, 0, "R10 A wins tie");
      checkRead(1, i, 0, 0, "R10 B loses tie");
      writeCycle(0, 0, 0, 1, i, 1, 16'h0F0F);
      checkRead(0, i, 0, 0, "R9 non-owner release ignored");
      writeCycle(1, i, 1, 0, 0, 0, 16'hF0F0);
      checkRead(1, i, 0, 0, "R9 withdrawn request not granted");
    end

    // R6: illegal select combination on a write
    setPort(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h003, 16'h0000);
    #1;
    check(aErr === 1'b1, "R6 err on write", int'(aErr), 1);
    check(aRdValid === 1'b0, "R6 no read on illegal", int'(aRdValid), 0);
    @(negedge clk);
    idleAll();
    checkRead(0, 3, 0, 0, "R6 illegal write ignored");
    // R6: illegal select combination on a read
    setPort(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h005, 16'h0000);
    #1;
    check(bErr === 1'b1 && bRdValid === 1'b0 && bRdata === 16'h0,
          "R6 illegal read", int'({bErr, bRdValid, bRdata}), int'({1'b1, 1'b0, 16'h0}));
    @(negedge clk);
    idleAll();

    // R5: semaphore select high, chip enable low is not a semaphore cycle
    setPort(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h002, 16'h0000);
    #1;
    check(aErr === 1'b0 && aRdValid === 1'b0, "R5 no access no err",
          int'({aErr, aRdValid}), 0);
    @(negedge clk);
    idleAll();
    checkRead(0, 2, 0, 0, "R5 unselected write ignored");

    // R7: output enable high blocks a read; write ignores output enable
    writeCycle(0, 0, 0, 1, 6, 0, 16'h1234);
    setPort(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h006, 16'h0000);
    #1;
    check(bRdValid === 1'b0 && bRdata === 16'h0, "R7 oe high no read",
          int'({bRdValid, bRdata}), 0);
    @(negedge clk);
    idleAll();
    checkRead(1, 6, 0, 0, "R7 oe-high cycle left flag alone");
    setPort(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h006, 16'h0001);
    #1;
    check(bRdValid === 1'b0, "R7 write is not a read", int'(bRdValid), 0);
    @(negedge clk);
    modelStep('0, '0, '0, 8'h40);
    idleAll();
    checkRead(1, 6, 0, 0, "R7 write with oe low applied");

    // Mixed sweep: random ops on both ports, then reads of random flags
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 600; n++) begin
      int opA, opB, ia, ib;
      bit [NF-1:0] qa, la, qb, lb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      opA = int'(lfsr[1:0]); opB = int'(lfsr[3:2]);
      ia = int'(lfsr[6:4]);  ib = int'(lfsr[9:7]);
      qa = '0; la = '0; qb = '0; lb = '0;
      // op 0 idle, 1 request, 2 release, 3 illegal write
      if (opA == 1) begin setPort(0, 0, 1, 0, 1, 0, 0, {lfsr[20:12], 3'(ia)}, {lfsr[31:17], 1'b0}); qa[ia] = 1; end
      if (opA == 2) begin setPort(0, 0, 1, 0, 1, 0, 0, {lfsr[20:12], 3'(ia)}, {lfsr[31:17], 1'b1}); la[ia] = 1; end
      if (opA == 3) setPort(0, 0, 0, 0, 1, 0, 0, {9'h0, 3'(ia)}, 16'h0);
      if (opB == 1) begin setPort(1, 0, 1, 0, 1, 1, 1, {lfsr[29:21], 3'(ib)}, {lfsr[15:1], 1'b0}); qb[ib] = 1; end
      if (opB == 2) begin setPort(1, 0, 1, 0, 1, 1, 1, {lfsr[29:21], 3'(ib)}, {lfsr[15:1], 1'b1}); lb[ib] = 1; end
      if (opB == 3) setPort(1, 0, 0, 0, 1, 0, 0, {9'h0, 3'(ib)}, 16'h0);
      #1;
      check(aErr === (opA == 3) && bErr === (opB == 3), "R6 err in sweep",
            int'({aErr, bErr}), int'({opA == 3, opB == 3}));
      @(negedge clk);
      modelStep(qa, la, qb, lb);
      idleAll();
      begin
        int ra, rb;
        logic [15:0] ea, eb;
        ra = int'(lfsr[12:10]); rb = int'(lfsr[15:13]);
        setPort(0, 0, 1, 1, 0, lfsr[16], lfsr[17], {9'h0F0, 3'(ra)}, 16'h0);
        setPort(1, 0, 1, 1, 0, lfsr[18], lfsr[19], {9'h10F, 3'(rb)}, 16'h0);
        #1;
        ea = (own[ra] == 1) ? 16'h0000 : 16'hFFFF;
        eb = (own[rb] == 2) ? 16'h0000 : 16'hFFFF;
        check(aRdata === ea && aRdValid, "R12 sweep read A", int'(aRdata), int'(ea));
        check(bRdata === eb && bRdValid, "R4 sweep read B", int'(bRdata), int'(eb));
        @(negedge clk);
        idleAll();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errCnt);
    $finish;
  end
endmodule